// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models a 256-byte serial EEPROM as seen by a host that drives the two wires of an I2C-style bus by software. Each time the host writes new sampled levels for the clock line and the data line, it raises `evValid` for one cycle. The block updates its state once per such event and always presents a single returned data-line level, `sdaOut`, which the host reads back as the level it sees on the bus.

A transfer begins with a start condition. The block then gathers an eight-bit command, acknowledges it, gathers an eight-bit word address, acknowledges that, and loads the byte stored at that address into an output shift register. When the low bit of the command is set (a read), the next address phase shifts that byte out, most significant bit first, on the returned data line. A single tick counter tracks the position across both phases; acknowledges are inserted through a pending flag instead of a dedicated state. The storage is filled before any traffic through a synchronous preload port.

Top module: `eeprom_bitbang`

## Requirements
- R1: After reset `sdaOut` is 1, the stored clock level is 1, no acknowledge is pending and no transfer is in progress.
- R2: An event where the clock is high on both the stored and the new sample and the data line falls is a start: it resets the bit position to the first command bit and clears the command, also in the middle of a transfer.
- R3: An event where the clock is high on both samples and the data line rises is a stop: no bit is taken and the returned level follows the host's data level.
- R4: With no transfer in progress and no acknowledge pending, clock pulses and data changes take no bits and never produce an acknowledge.
- R5: A bit is taken only on a clock rising edge (stored clock 0, new clock 1) whose data level equals the stored returned level; a rising edge with a different data level takes no bit.
- R6: After the eighth command bit, and again after the eighth address bit, an acknowledge is pending; the next clock rising edge returns 0 whatever the host drives, takes no bit and clears the pending acknowledge.
- R7: Eight address bits are taken most significant bit first after the command acknowledge; at the eighth the byte at that address is loaded into the output register and the transfer returns to waiting for a start.
- R8: When command bit 0 is 1, each of the eight rising edges of the following address phase returns the next bit of the loaded byte, most significant bit first.
- R9: On every event other than a rising edge that inserts an acknowledge or a read bit, `sdaOut` becomes the host's new data level.
- R10: A cycle with `loadEn` high writes `loadData` into the storage location `loadAddr`; the byte is what a later read returns.
- R11: In cycles with `evValid` low, `sdaOut` and the transfer state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | One host sample event this cycle |
| evScl | input | 1 | Host clock-line level for this event |
| evSda | input | 1 | Host data-line level for this event |
| sdaOut | output | 1 | Returned data-line level |
| loadEn | input | 1 | Preload write strobe |
| loadAddr | input | 8 | Preload address |
| loadData | input | 8 | Preload byte |

## Verification
The assertions assume that each event carries one coherent pair of line levels and that the host holds the inputs meaningless only in cycles where `evValid` is low; they also rely on the preload port being quiet while bits move. The stimulus keeps to this by filling the storage completely before the first event, spacing events one idle cycle apart, and building every bit as a data setup with the clock low, a rising edge and a falling edge, with deliberate exceptions only where a rule about illegal data changes, restarts or unstarted traffic is being exercised.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Strobes from the bit controller to the storage datapath.
  typedef struct packed {
    logic clrCmd;    // start seen: empty the command register
    logic shiftCmd;  // take one command bit
    logic shiftAddr; // take one address bit, shift the output byte
    logic loadData;  // last address bit: fetch the addressed byte
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_bitctl.sv
module eeprom_bitctl
  import eeprom_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  input  logic              evScl,
  input  logic              evSda,
  input  logic              cmdRead,
  input  logic              dataMsb,
  output dpStrobe_t         stb,
  output logic              sdaOut,
  output logic [TICK_W-1:0] tickQ,
  output logic              ackQ,
  output logic              sclQ
);

  localparam logic [TICK_W-1:0] CmdEnd  = TICK_W'(CMD_W + 1);
  localparam logic [TICK_W-1:0] AddrEnd = TICK_W'(CMD_W + ADDR_W + 1);
  localparam logic [TICK_W-1:0] FirstBit = TICK_W'(1);

  logic              sdaQ;
  logic [TICK_W-1:0] tickN;
  logic              ackN;
  logic              sdaN;
  logic              rise;
  logic              highChange;

  assign rise       = !sclQ && evScl;
  assign highChange = sclQ && evScl && (sdaQ != evSda);

  always_comb begin
    stb   = '0;
    tickN = tickQ;
    ackN  = ackQ;
    sdaN  = evSda;
    if (evValid) begin
      if (highChange) begin
        if (!evSda) begin
          tickN      = FirstBit;
          stb.clrCmd = 1'b1;
        end
      end else if (tickQ == '0 && !ackQ) begin
        tickN = tickQ;
      end else if (rise) begin
        if (ackQ) begin
          sdaN = 1'b0;
          ackN = 1'b0;
        end else if (sdaQ == evSda) begin
          tickN = tickQ + FirstBit;
          if (tickQ < CmdEnd) begin
            stb.shiftCmd = 1'b1;
            if (tickN == CmdEnd) ackN = 1'b1;
          end else begin
            stb.shiftAddr = 1'b1;
            if (cmdRead) sdaN = dataMsb;
            if (tickN == AddrEnd) begin
              stb.loadData = 1'b1;
              ackN         = 1'b1;
              tickN        = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickQ <= '0;
      ackQ  <= 1'b0;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else if (evValid) begin
      tickQ <= tickN;
      ackQ  <= ackN;
      sclQ  <= evScl;
      sdaQ  <= sdaN;
    end
  end

  assign sdaOut = sdaQ;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic              bitIn,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              cmdRead,
  output logic              dataMsb
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [CMD_W-1:0]  cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] addrNext;

  assign addrNext = {addrQ[ADDR_W-2:0], bitIn};

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (stb.clrCmd) cmdQ <= '0;
      else if (stb.shiftCmd) cmdQ <= {cmdQ[CMD_W-2:0], bitIn};
      if (stb.shiftAddr) begin
        addrQ <= addrNext;
        if (stb.loadData) dataQ <= mem[addrNext];
        else dataQ <= {dataQ[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign cmdRead = cmdQ[0];
  assign dataMsb = dataQ[DATA_W-1];

endmodule

// File: rtl/eeprom_bitbang.sv
module eeprom_bitbang
  import eeprom_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  input  logic              evScl,
  input  logic              evSda,
  output logic              sdaOut,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData
);

  localparam int TICK_W = $clog2(CMD_W + ADDR_W + 2);

  dpStrobe_t         stb;
  logic              cmdRead;
  logic              dataMsb;
  logic [TICK_W-1:0] tickQ;
  logic              ackQ;
  logic              sclQ;

  eeprom_bitctl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evScl(evScl), .evSda(evSda),
    .cmdRead(cmdRead), .dataMsb(dataMsb), .stb(stb), .sdaOut(sdaOut),
    .tickQ(tickQ), .ackQ(ackQ), .sclQ(sclQ)
  );

  eeprom_store #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bitIn(evSda),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .cmdRead(cmdRead), .dataMsb(dataMsb)
  );

endmodule

// File: rtl/eeprom_bitbang_chk.sv
module eeprom_bitbang_chk #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evValid,
  input logic              evScl,
  input logic              evSda,
  input logic              sdaOut,
  input logic [TICK_W-1:0] tickQ,
  input logic              ackQ,
  input logic              sclQ
);

  localparam int TickMax = CMD_W + ADDR_W;

  p_tick_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tickQ) <= TickMax);

  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && sclQ && evScl && sdaOut && !evSda |=> tickQ == TICK_W'(1));

  p_ack_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && ackQ && !sclQ && evScl |=> !sdaOut && !ackQ);

  p_no_bit_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && !sclQ && evScl && !ackQ && (sdaOut != evSda) |=> $stable(tickQ));

  p_idle_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && tickQ == '0 && !ackQ && !(sclQ && evScl && sdaOut && !evSda)
    |=> tickQ == '0 && !ackQ);

  p_follow_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evValid && !(!sclQ && evScl) |=> sdaOut == $past(evSda));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !evValid |=> $stable(sdaOut) && $stable(tickQ) && $stable(ackQ));

endmodule

bind eeprom_bitbang eeprom_bitbang_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evValid(evValid), .evScl(evScl), .evSda(evSda),
  .sdaOut(sdaOut), .tickQ(tickQ), .ackQ(ackQ), .sclQ(sclQ)
);

// File: tb/test_eeprom_bitbang.sv
module test_eeprom_bitbang;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evValid = 1'b0;
  logic       evScl = 1'b1;
  logic       evSda = 1'b1;
  logic       sdaOut;
  logic       loadEn = 1'b0;
  logic [7:0] loadAddr = '0;
  logic [7:0] loadData = '0;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural reference state
  int refMem [256];
  int mTick, mAck, mCmd, mAddr, mData, mScl, mSda;

  always #(ClkPeriod/2) clk = ~clk;

  eeprom_bitbang i_eeprom_bitbang (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evScl(evScl), .evSda(evSda),
    .sdaOut(sdaOut), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mTick = 0; mAck = 0; mCmd = 0; mAddr = 0; mData = 0; mScl = 1; mSda = 1;
  endtask

  task automatic modelStep(input int scl, input int sda);
    int nsda;
    nsda = sda;
    if (mScl == 1 && scl == 1 && mSda != sda) begin
      if (sda == 0) begin mTick = 1; mCmd = 0; end
    end else if (mTick == 0 && mAck == 0) begin
      nsda = sda;
    end else if (mScl == 0 && scl == 1) begin
      if (mAck != 0) begin
        nsda = 0; mAck = 0;
      end else if (mSda == sda) begin
        if (mTick < 9) begin
          mCmd = ((mCmd * 2) + sda) % 256;
          mTick++;
          if (mTick == 9) mAck = 1;
        end else begin
          if (mCmd % 2 == 1) nsda = (mData / 128) % 2;
          mAddr = ((mAddr * 2) + sda) % 256;
          mData = (mData * 2) % 256;
          mTick++;
          if (mTick == 17) begin
            mData = refMem[mAddr]; mAck = 1; mTick = 0;
          end
        end
      end
    end
    mScl = scl; mSda = nsda;
  endtask

  // one host event, compared after the registered update
  task automatic ev(input int scl, input int sda);
    @(negedge clk);
    evValid = 1'b1; evScl = scl[0]; evSda = sda[0];
    modelStep(scl, sda);
    @(negedge clk);
    evValid = 1'b0;
    check(curTag, int'(sdaOut), mSda);
  endtask

  task automatic sendBit(input int b, output int seen);
    ev(0, b);
    ev(1, b);
    seen = int'(sdaOut);
    ev(0, b);
  endtask

  task automatic sendByte(input int v);
    int s;
    for (int k = 7; k >= 0; k--) sendBit((v >> k) % 2, s);
  endtask

  task automatic startCond();
    ev(0, 1); ev(1, 1); ev(1, 0); ev(0, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    int s;
    int rd;
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    curTag = "R1";
    check("R1 reset sdaOut", int'(sdaOut), 1);

    // R10: preload every location
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = a[7:0]; loadData = 8'((a * 37 + 11) ^ 8'h5A);
      refMem[a] = (a * 37 + 11) ^ 8'h5A;
      refMem[a] = refMem[a] % 256;
    end
    @(negedge clk);
    loadEn = 1'b0;

    // R4: traffic with no start is ignored, host 0 bits never acked
    curTag = "R4";
    for (int k = 0; k < 10; k++) sendBit(k % 2, s);
    sendBit(1, s);
    check("R4 no ack without start", s, 1);

    // R2 restart mid-command, then full write of address 0x3C
    curTag = "R2";
    ev(0, 1); ev(1, 1);
    startCond();
    sendBit(1, s); sendBit(0, s); sendBit(1, s);
    ev(0, 1); ev(1, 1); ev(1, 0); ev(0, 0);
    curTag = "R6";
    sendByte(8'hA0);
    sendBit(1, s);
    check("R6 command ack", s, 0);

    // R5: an illegal change on a rising edge takes no bit
    curTag = "R5";
    ev(0, 0); ev(1, 1); ev(0, 1);
    curTag = "R7";
    sendByte(8'h3C);
    sendBit(1, s);
    check("R7 address ack", s, 0);

    // R8/R10: read back the byte loaded from 0x3C
    curTag = "R8";
    startCond();
    sendByte(8'hA1);
    sendBit(1, s);
    check("R8 read command ack", s, 0);
    rd = 0;
    for (int k = 0; k < 8; k++) begin
      sendBit(1, s);
      rd = rd * 2 + s;
    end
    check("R8 read byte bits", rd, refMem[8'h3C]);
    check("R10 preloaded byte", rd, ((8'h3C * 37 + 11) ^ 8'h5A) % 256);
    sendBit(1, s);
    check("R6 address ack after read", s, 0);

    // R8 second read returns byte at 0xFF loaded by the last phase
    startCond();
    sendByte(8'h01);
    sendBit(0, s);
    rd = 0;
    for (int k = 0; k < 8; k++) begin
      sendBit(0, s);
      rd = rd * 2 + s;
    end
    check("R8 second read", rd, refMem[255]);
    sendBit(1, s);

    // R3: stop condition, then R9 follow host
    curTag = "R3";
    ev(0, 0); ev(1, 0); ev(1, 1);
    check("R3 stop follows host", int'(sdaOut), 1);
    curTag = "R9";
    ev(1, 0); ev(0, 0); ev(0, 1);
    check("R9 follow host", int'(sdaOut), 1);

    // R11: idle cycles leave the output unchanged
    curTag = "R11";
    ev(0, 0);
    repeat (5) @(negedge clk);
    check("R11 idle stable", int'(sdaOut), 0);

    finish();
  end

endmodule